// File: doc/BRIEF.md
# Masked Vector Float-to-Unsigned Converter

This block turns a vector of IEEE-754 single-precision lanes into unsigned 32-bit integers, one result for each 32-bit lane. The lane count is a build-time parameter (4, 8 or 16 lanes, for 128-, 256- or 512-bit vectors). The result is zero-extended to a fixed maximum width of 16 lanes. An operation is issued by holding `opValid` high for one rising clock edge. The destination register, the undefined-operation pulse and the two sticky flags then update on that edge.

Each lane rounds its value under one of four rounding modes. The mode normally comes from a global control field. An embedded override replaces it only for a full-width register-source operation with the broadcast/rounding bit set. Values that do not fit in 0 to 2^32−1 saturate to all-ones and raise the sticky invalid flag. A memory-source operation with the broadcast bit set feeds element 0 to every lane. A per-lane write mask, qualified by a mask enable, decides which lanes take their converted value. Each other lane either keeps the value presented on `priorDst` (merging) or is cleared (zeroing). A 4-bit reserved operand field must read 1111b. Any other value flags the operation as undefined and leaves the destination and the flags untouched.

Top module: `fcvtu_vec`

## Requirements
- R1: On a rising edge with `opValid` high and `rsvdField` = 4'b1111, each active lane j is written with the unsigned conversion of source bits 32j+31:32j. The result is visible after that edge. With `opValid` low, `dstVec` holds its value.
- R2: An inexact value is rounded by the selected 2-bit mode. The encodings are 00 = to nearest, ties to even; 01 = toward −∞; 10 = toward +∞; 11 = toward zero.
- R3: The mode is taken from `embRm` only when `srcIsMem` = 0, `bcastBit` = 1 and the lane count equals the maximum (16). In every other case it is taken from `globalRm`.
- R4: NaN, ±∞, a rounded result that is negative and nonzero, and a rounded result of 2^32 or more each return 32'hFFFFFFFF. Each of these sets `flagInvalid`, which stays set until reset.
- R5: A negative value that rounds to zero returns 0. It sets only the precision flag, and `flagInvalid` is not set. −0.0 returns 0 with no flag.
- R6: `flagPrecision` is set, and stays set until reset, when an active lane's conversion is inexact and not invalid. Inactive lanes contribute to neither flag.
- R7: With `srcIsMem` = 1 and `bcastBit` = 1, every lane converts source bits 31:0. A register source with `bcastBit` = 1 does not broadcast.
- R8: A lane is active when `maskEn` = 0 or when its bit in `wrMask` is 1.
- R9: An inactive lane takes its `priorDst` lane when `zeroMode` = 0, and 0 when `zeroMode` = 1.
- R10: `dstVec` bits from LANES·32 up to the maximum width are always 0.
- R11: With `opValid` high and `rsvdField` ≠ 4'b1111, `udFault` is 1 for the following cycle. `dstVec`, `flagInvalid` and `flagPrecision` are unchanged. `udFault` is 0 after any other edge.
- R12: While `rstN` is low, `dstVec`, `flagInvalid`, `flagPrecision` and `udFault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Issue strobe for one operation |
| srcVec | input | LANES*32 | Source lanes (element 0 in bits 31:0) |
| srcIsMem | input | 1 | 1 = memory source, 0 = register source |
| bcastBit | input | 1 | Broadcast (memory) or rounding-override (register) bit |
| rsvdField | input | 4 | Reserved operand field, must be 4'b1111 |
| wrMask | input | LANES | Per-lane write mask |
| maskEn | input | 1 | 1 = honour `wrMask` |
| zeroMode | input | 1 | 1 = zero inactive lanes, 0 = merge |
| priorDst | input | LANES*32 | Prior destination value used for merging |
| globalRm | input | 2 | Global rounding mode |
| embRm | input | 2 | Embedded rounding override |
| dstVec | output | MAX_LANES*32 | Destination vector, zero-extended |
| flagInvalid | output | 1 | Sticky invalid flag |
| flagPrecision | output | 1 | Sticky precision flag |
| udFault | output | 1 | Undefined-operation pulse |

## Verification
Every result of this block is due one cycle after issue. `dstVec`, `udFault` and both flags are all registered on the rising edge that sees `opValid` high. The bench changes inputs on a falling edge and raises `opValid` for exactly one rising edge. It samples on the following falling edge, so each check reads the value from that single edge. The flags are sticky and there is no clear input, so the bench resets the block before every table vector and before each flag-sensitive directed test. A second copy built with 4 lanes runs on the same stimulus. It shows the zero-extension above 128 bits and the fallback to the global mode when the vector is not full width.

// File: rtl/fcvtu_pkg.sv
package fcvtu_pkg;

  localparam int LANE_W = 32;

  localparam logic [1:0] RM_NEAR  = 2'b00;
  localparam logic [1:0] RM_DOWN  = 2'b01;
  localparam logic [1:0] RM_UP    = 2'b10;
  localparam logic [1:0] RM_TRUNC = 2'b11;

  localparam logic [3:0] RSVD_OK = 4'b1111;

  typedef struct packed {
    logic       commit;
    logic       bcast;
    logic       maskOn;
    logic       zeroFill;
    logic [1:0] rm;
  } cvtStrobe_t;

endpackage

// File: rtl/fcvtu_lane.sv
module fcvtu_lane
  import fcvtu_pkg::*;
(
  input  logic [LANE_W-1:0] fIn,
  input  logic [1:0]        rm,
  output logic [LANE_W-1:0] res,
  output logic              inv,
  output logic              inx
);

  logic        sgn;
  logic [7:0]  ex;
  logic [23:0] sig;
  logic [7:0]  shAmt;
  logic [55:0] wide;
  logic [32:0] mag;
  logic [32:0] rounded;
  logic        guard;
  logic        sticky;
  logic        lost;
  logic        tooBig;
  logic        up;

  always_comb begin
    sgn    = fIn[31];
    ex     = fIn[30:23];
    sig    = {(ex != 8'd0), fIn[22:0]};
    wide   = '0;
    mag    = '0;
    guard  = 1'b0;
    sticky = 1'b0;
    tooBig = 1'b0;
    shAmt  = '0;
    if (ex >= 8'd150) begin
      // integer magnitude, exact; more than 8 left shifts leaves 32 bits
      shAmt  = ex - 8'd150;
      tooBig = (shAmt > 8'd8);
      mag    = {9'd0, sig} << shAmt[3:0];
    end else begin
      shAmt = (ex == 8'd0) ? 8'd149 : (8'd150 - ex);
      if (shAmt > 8'd26) shAmt = 8'd26;
      wide   = {sig, 32'd0} >> shAmt;
      mag    = {9'd0, wide[55:32]};
      guard  = wide[31];
      sticky = |wide[30:0];
    end
  end

  always_comb begin
    lost = guard | sticky;
    case (rm)
      RM_NEAR: up = guard & (sticky | mag[0]);
      RM_DOWN: up = sgn & lost;
      RM_UP:   up = ~sgn & lost;
      default: up = 1'b0;
    endcase
    rounded = mag + {32'd0, up};
    inv = (ex == 8'hFF) | tooBig | rounded[32] | (sgn & (rounded != 33'd0));
    res = inv ? '1 : rounded[31:0];
    inx = lost & ~inv;
  end

endmodule

// File: rtl/fcvtu_control.sv
module fcvtu_control
  import fcvtu_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int MAX_LANES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       srcIsMem,
  input  logic       bcastBit,
  input  logic [3:0] rsvdField,
  input  logic       maskEn,
  input  logic       zeroMode,
  input  logic [1:0] globalRm,
  input  logic [1:0] embRm,
  input  logic       anyInv,
  input  logic       anyInx,
  output cvtStrobe_t strobe,
  output logic       flagInvalid,
  output logic       flagPrecision,
  output logic       udFault
);

  localparam logic FULL_VL = (LANES == MAX_LANES);

  logic legal;
  logic useEmb;

  always_comb begin
    legal           = (rsvdField == RSVD_OK);
    useEmb          = FULL_VL & ~srcIsMem & bcastBit;
    strobe.commit   = opValid & legal;
    strobe.bcast    = srcIsMem & bcastBit;
    strobe.maskOn   = maskEn;
    strobe.zeroFill = zeroMode;
    strobe.rm       = useEmb ? embRm : globalRm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagInvalid   <= 1'b0;
      flagPrecision <= 1'b0;
      udFault       <= 1'b0;
    end else begin
      udFault <= opValid & ~legal;
      if (strobe.commit) begin
        flagInvalid   <= flagInvalid | anyInv;
        flagPrecision <= flagPrecision | anyInx;
      end
    end
  end

endmodule

// File: rtl/fcvtu_datapath.sv
module fcvtu_datapath
  import fcvtu_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int MAX_LANES = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cvtStrobe_t                    strobe,
  input  logic [LANES*LANE_W-1:0]       srcVec,
  input  logic [LANES-1:0]              wrMask,
  input  logic [LANES*LANE_W-1:0]       priorDst,
  output logic [MAX_LANES*LANE_W-1:0]   dstVec,
  output logic                          anyInv,
  output logic                          anyInx
);

  localparam int VL   = LANES * LANE_W;
  localparam int MAXW = MAX_LANES * LANE_W;

  logic [VL-1:0]    nextVec;
  logic [LANES-1:0] actInv;
  logic [LANES-1:0] actInx;
  logic [MAXW-1:0]  nextFull;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] laneSrc;
    logic [LANE_W-1:0] laneRes;
    logic              laneInv;
    logic              laneInx;
    logic              active;

    assign laneSrc = strobe.bcast ? srcVec[LANE_W-1:0] : srcVec[j*LANE_W +: LANE_W];

    fcvtu_lane u_lane (
      .fIn (laneSrc),
      .rm  (strobe.rm),
      .res (laneRes),
      .inv (laneInv),
      .inx (laneInx)
    );

    assign active    = ~strobe.maskOn | wrMask[j];
    assign actInv[j] = active & laneInv;
    assign actInx[j] = active & laneInx;
    assign nextVec[j*LANE_W +: LANE_W] = active ? laneRes :
                                         (strobe.zeroFill ? '0 : priorDst[j*LANE_W +: LANE_W]);
  end

  assign anyInv = |actInv;
  assign anyInx = |actInx;

  always_comb begin
    nextFull         = '0;
    nextFull[VL-1:0] = nextVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dstVec <= '0;
    else if (strobe.commit) dstVec <= nextFull;
  end

endmodule

// File: rtl/fcvtu_vec.sv
module fcvtu_vec
  import fcvtu_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int MAX_LANES = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        opValid,
  input  logic [LANES*32-1:0]         srcVec,
  input  logic                        srcIsMem,
  input  logic                        bcastBit,
  input  logic [3:0]                  rsvdField,
  input  logic [LANES-1:0]            wrMask,
  input  logic                        maskEn,
  input  logic                        zeroMode,
  input  logic [LANES*32-1:0]         priorDst,
  input  logic [1:0]                  globalRm,
  input  logic [1:0]                  embRm,
  output logic [MAX_LANES*32-1:0]     dstVec,
  output logic                        flagInvalid,
  output logic                        flagPrecision,
  output logic                        udFault
);

  cvtStrobe_t strobe;
  logic       anyInv;
  logic       anyInx;

  fcvtu_control #(.LANES(LANES), .MAX_LANES(MAX_LANES)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .opValid       (opValid),
    .srcIsMem      (srcIsMem),
    .bcastBit      (bcastBit),
    .rsvdField     (rsvdField),
    .maskEn        (maskEn),
    .zeroMode      (zeroMode),
    .globalRm      (globalRm),
    .embRm         (embRm),
    .anyInv        (anyInv),
    .anyInx        (anyInx),
    .strobe        (strobe),
    .flagInvalid   (flagInvalid),
    .flagPrecision (flagPrecision),
    .udFault       (udFault)
  );

  fcvtu_datapath #(.LANES(LANES), .MAX_LANES(MAX_LANES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .srcVec   (srcVec),
    .wrMask   (wrMask),
    .priorDst (priorDst),
    .dstVec   (dstVec),
    .anyInv   (anyInv),
    .anyInx   (anyInx)
  );

endmodule

// File: rtl/fcvtu_vec_chk.sv
module fcvtu_vec_chk #(
  parameter int LANES     = 16,
  parameter int MAX_LANES = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    opValid,
  input logic [3:0]              rsvdField,
  input logic [31:0]             lane0Src,
  input logic                    lane0Mask,
  input logic                    maskEn,
  input logic                    zeroMode,
  input logic [31:0]             lane0Prior,
  input logic [MAX_LANES*32-1:0] dstVec,
  input logic                    flagInvalid,
  input logic                    flagPrecision,
  input logic                    udFault
);

  localparam int VL   = LANES * 32;
  localparam int MAXW = MAX_LANES * 32;

  logic issueOk;
  logic issueBad;
  logic lane0Off;
  assign issueOk  = opValid && (rsvdField == 4'b1111);
  assign issueBad = opValid && (rsvdField != 4'b1111);
  assign lane0Off = maskEn && !lane0Mask;

  p_ud_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    issueBad |=> udFault);

  p_ud_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    issueBad |=> ($stable(dstVec) && $stable(flagInvalid) && $stable(flagPrecision)));

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(dstVec));

  p_sticky_inv_r4: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalid |=> flagInvalid);

  p_sticky_inx_r6: assert property (@(posedge clk) disable iff (!rstN)
    flagPrecision |=> flagPrecision);

  p_nan_sat_r4: assert property (@(posedge clk) disable iff (!rstN)
    (issueOk && !lane0Off && (lane0Src[30:23] == 8'hFF))
      |=> (dstVec[31:0] == 32'hFFFF_FFFF) && flagInvalid);

  p_zero_lane_r9: assert property (@(posedge clk) disable iff (!rstN)
    (issueOk && lane0Off && zeroMode) |=> (dstVec[31:0] == 32'd0));

  p_merge_lane_r9: assert property (@(posedge clk) disable iff (!rstN)
    (issueOk && lane0Off && !zeroMode) |=> (dstVec[31:0] == $past(lane0Prior)));

  if (LANES < MAX_LANES) begin : g_upper
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
      dstVec[MAXW-1:VL] == '0);
  end

endmodule

bind fcvtu_vec fcvtu_vec_chk #(.LANES(LANES), .MAX_LANES(MAX_LANES)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .opValid       (opValid),
  .rsvdField     (rsvdField),
  .lane0Src      (srcVec[31:0]),
  .lane0Mask     (wrMask[0]),
  .maskEn        (maskEn),
  .zeroMode      (zeroMode),
  .lane0Prior    (priorDst[31:0]),
  .dstVec        (dstVec),
  .flagInvalid   (flagInvalid),
  .flagPrecision (flagPrecision),
  .udFault       (udFault)
);

// File: tb/fcvtu_vec_test.sv
`timescale 1ns/1ps
module fcvtu_vec_test;

  typedef struct packed {
    logic [31:0] f;
    logic [1:0]  rm;
    logic [31:0] exp;
    logic        inv;
    logic        inx;
  } vec_t;

  localparam int NV = 21;
  // rounding (R2), saturation (R4), negative-to-zero (R5)
  localparam vec_t VEC [NV] = '{
    '{32'h3F800000, 2'd0, 32'd1,        1'b0, 1'b0},
    '{32'h40200000, 2'd0, 32'd2,        1'b0, 1'b1},
    '{32'h40600000, 2'd0, 32'd4,        1'b0, 1'b1},
    '{32'h40200000, 2'd1, 32'd2,        1'b0, 1'b1},
    '{32'h40200000, 2'd2, 32'd3,        1'b0, 1'b1},
    '{32'h40200000, 2'd3, 32'd2,        1'b0, 1'b1},
    '{32'hBECCCCCD, 2'd0, 32'd0,        1'b0, 1'b1},
    '{32'hBECCCCCD, 2'd1, 32'hFFFFFFFF, 1'b1, 1'b0},
    '{32'hBECCCCCD, 2'd2, 32'd0,        1'b0, 1'b1},
    '{32'hBF800000, 2'd3, 32'hFFFFFFFF, 1'b1, 1'b0},
    '{32'h7FC00000, 2'd0, 32'hFFFFFFFF, 1'b1, 1'b0},
    '{32'h7F800000, 2'd3, 32'hFFFFFFFF, 1'b1, 1'b0},
    '{32'hFF800000, 2'd0, 32'hFFFFFFFF, 1'b1, 1'b0},
    '{32'h4F7FFFFF, 2'd0, 32'hFFFFFF00, 1'b0, 1'b0},
    '{32'h4F800000, 2'd3, 32'hFFFFFFFF, 1'b1, 1'b0},
    '{32'h80000000, 2'd1, 32'd0,        1'b0, 1'b0},
    '{32'h3F000000, 2'd0, 32'd0,        1'b0, 1'b1},
    '{32'h3F000000, 2'd2, 32'd1,        1'b0, 1'b1},
    '{32'h00000001, 2'd2, 32'd1,        1'b0, 1'b1},
    '{32'h47F12000, 2'd1, 32'h0001E240, 1'b0, 1'b0},
    '{32'h3FC00000, 2'd0, 32'd2,        1'b0, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rstN;
  logic         opValid;
  logic [511:0] srcVec;
  logic         srcIsMem;
  logic         bcastBit;
  logic [3:0]   rsvdField;
  logic [15:0]  wrMask;
  logic         maskEn;
  logic         zeroMode;
  logic [511:0] priorDst;
  logic [1:0]   globalRm;
  logic [1:0]   embRm;
  logic [511:0] dstVec;
  logic         flagInvalid, flagPrecision, udFault;
  logic [511:0] dstVec4;
  logic         flagInvalid4, flagPrecision4, udFault4;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fcvtu_vec uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .srcVec(srcVec),
    .srcIsMem(srcIsMem), .bcastBit(bcastBit), .rsvdField(rsvdField),
    .wrMask(wrMask), .maskEn(maskEn), .zeroMode(zeroMode),
    .priorDst(priorDst), .globalRm(globalRm), .embRm(embRm),
    .dstVec(dstVec), .flagInvalid(flagInvalid),
    .flagPrecision(flagPrecision), .udFault(udFault)
  );

  fcvtu_vec #(.LANES(4)) uut4 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .srcVec(srcVec[127:0]),
    .srcIsMem(srcIsMem), .bcastBit(bcastBit), .rsvdField(rsvdField),
    .wrMask(wrMask[3:0]), .maskEn(maskEn), .zeroMode(zeroMode),
    .priorDst(priorDst[127:0]), .globalRm(globalRm), .embRm(embRm),
    .dstVec(dstVec4), .flagInvalid(flagInvalid4),
    .flagPrecision(flagPrecision4), .udFault(udFault4)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] i2f(input int unsigned n);
    int msb = 0;
    for (int b = 0; b < 24; b++) if (n[b]) msb = b;
    return {1'b0, 8'(127 + msb), 23'((n << (23 - msb)) & 32'h7FFFFF)};
  endfunction

  task automatic setDefaults();
    opValid = 0; srcVec = '0; srcIsMem = 0; bcastBit = 0; rsvdField = 4'b1111;
    wrMask = '0; maskEn = 0; zeroMode = 0; priorDst = '0; globalRm = 2'd0; embRm = 2'd0;
  endtask

  task automatic resetDut();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic fire();
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    setDefaults();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 dst", {31'd0, |dstVec}, 32'd0);
    chk("R12 inv", {31'd0, flagInvalid}, 32'd0);
    chk("R12 inx", {31'd0, flagPrecision}, 32'd0);
    chk("R12 ud", {31'd0, udFault}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: lane 0 carries the vector, other lanes +0.0
    for (int i = 0; i < NV; i++) begin
      resetDut();
      setDefaults();
      srcVec[31:0] = VEC[i].f;
      globalRm = VEC[i].rm;
      fire();
      chk($sformatf("R2 table %0d value", i), dstVec[31:0], VEC[i].exp);
      chk($sformatf("R4 table %0d invalid", i), {31'd0, flagInvalid}, {31'd0, VEC[i].inv});
      chk($sformatf("R5 table %0d precision", i), {31'd0, flagPrecision}, {31'd0, VEC[i].inx});
      chk($sformatf("R1 table %0d other lanes", i), {31'd0, |dstVec[511:32]}, 32'd0);
    end

    // R1 distinct lanes, plus R10 on the 4-lane copy
    resetDut();
    setDefaults();
    for (int j = 0; j < 16; j++) srcVec[j*32 +: 32] = i2f(j * 1000 + 3);
    fire();
    for (int j = 0; j < 16; j++) chk($sformatf("R1 lane %0d", j), dstVec[j*32 +: 32], j * 1000 + 3);
    for (int j = 0; j < 4; j++) chk($sformatf("R1 narrow lane %0d", j), dstVec4[j*32 +: 32], j * 1000 + 3);
    chk("R10 narrow upper zero", {31'd0, |dstVec4[511:128]}, 32'd0);

    // R7 memory broadcast
    setDefaults();
    for (int j = 0; j < 16; j++) srcVec[j*32 +: 32] = i2f(j + 20);
    srcVec[31:0] = i2f(7);
    srcIsMem = 1; bcastBit = 1;
    fire();
    for (int j = 0; j < 16; j++) chk($sformatf("R7 bcast lane %0d", j), dstVec[j*32 +: 32], 32'd7);

    // R3 register source with override bit: embedded mode, no broadcast
    setDefaults();
    srcVec[31:0] = 32'h40200000; srcVec[63:32] = 32'h40200000; srcVec[95:64] = i2f(9);
    bcastBit = 1; globalRm = 2'd0; embRm = 2'd2;
    fire();
    chk("R3 emb lane0", dstVec[31:0], 32'd3);
    chk("R3 emb lane1", dstVec[63:32], 32'd3);
    chk("R7 reg no bcast lane2", dstVec[95:64], 32'd9);
    chk("R3 narrow uses global", dstVec4[31:0], 32'd2);
    // R3 memory source: global mode even with bit set
    srcIsMem = 1;
    fire();
    chk("R3 mem global lane0", dstVec[31:0], 32'd2);
    chk("R3 mem global lane15", dstVec[511:480], 32'd2);

    // R9 merging and zeroing
    setDefaults();
    for (int j = 0; j < 16; j++) begin
      srcVec[j*32 +: 32] = i2f(j + 1);
      priorDst[j*32 +: 32] = 32'hA5000000 + j;
    end
    maskEn = 1; wrMask = 16'h00FF; zeroMode = 0;
    fire();
    for (int j = 0; j < 16; j++)
      chk($sformatf("R9 merge lane %0d", j), dstVec[j*32 +: 32], (j < 8) ? j + 1 : 32'hA5000000 + j);
    zeroMode = 1;
    fire();
    for (int j = 8; j < 16; j++) chk($sformatf("R9 zero lane %0d", j), dstVec[j*32 +: 32], 32'd0);
    // R8 mask disabled: all written
    maskEn = 0; wrMask = 16'h0000;
    fire();
    for (int j = 0; j < 16; j++) chk($sformatf("R8 unmasked lane %0d", j), dstVec[j*32 +: 32], j + 1);

    // R6 inactive lanes add no flags
    resetDut();
    setDefaults();
    for (int j = 0; j < 16; j++) srcVec[j*32 +: 32] = i2f(j + 1);
    srcVec[191:160] = 32'h7FC00000;
    srcVec[223:192] = 32'h40200000;
    maskEn = 1; zeroMode = 1; wrMask = 16'hFF9F;
    fire();
    chk("R6 inactive inv", {31'd0, flagInvalid}, 32'd0);
    chk("R6 inactive inx", {31'd0, flagPrecision}, 32'd0);
    chk("R6 lane5 zeroed", dstVec[191:160], 32'd0);
    chk("R6 lane6 zeroed", dstVec[223:192], 32'd0);

    // R11 undefined operation
    resetDut();
    setDefaults();
    srcVec[31:0] = 32'h40200000;
    fire();
    chk("R11 legal no ud", {31'd0, udFault}, 32'd0);
    chk("R6 set inx", {31'd0, flagPrecision}, 32'd1);
    srcVec[31:0] = 32'h7FC00000;
    rsvdField = 4'b0111;
    fire();
    chk("R11 ud pulse", {31'd0, udFault}, 32'd1);
    chk("R11 dst kept", dstVec[31:0], 32'd2);
    chk("R11 inv kept", {31'd0, flagInvalid}, 32'd0);
    chk("R11 inx kept", {31'd0, flagPrecision}, 32'd1);
    @(negedge clk);
    chk("R11 ud clears", {31'd0, udFault}, 32'd0);
    // R6 stickiness across an exact conversion
    rsvdField = 4'b1111;
    srcVec[31:0] = i2f(5);
    fire();
    chk("R6 sticky inx", {31'd0, flagPrecision}, 32'd1);
    chk("R1 after ud", dstVec[31:0], 32'd5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule